// File: doc/BRIEF.md
# Predecoded Loop Replay Buffer

This block keeps the already decoded control words of the instructions that follow a frequently taken branch. Later passes through the loop can then take each control word straight from the buffer and skip the prefetch and dispatch stages. While the core is in store mode (`store_mode` high), every instruction leaving decode writes its control word. While the core is in fetch mode (`fetch_mode` high), every instruction looks up its control word. One cycle later the block reports a hit together with the word, or a miss. On a miss the surrounding mode logic leaves fetch mode and goes back to instruction memory.

Bundles are stored compressed. A two-slot bundle may therefore pass through dispatch twice under the same PC, once for each half. To keep the two passes apart, each entry is keyed by the PC together with a one-bit half-select index. A small tracker produces this index from the parallel bits of the two slots. The index register advances when an instruction moves from decode into the first execute stage (`dec_adv`). Both the write and the lookup use the value the index register holds in that cycle.

The default buffer has 16 fully associative entries. New keys are placed round-robin. A store to a key that is already present updates that entry in place.

Top module: `loop_replay_buf`

## Requirements
- R1: With `dec_adv` high, the change bit is `slot_a_par | slot_b_par`. The half index becomes 1 when the change bit equals the current index and 0 otherwise. A split bundle (both parallel bits 0) therefore toggles the index, and a full bundle keeps it. Both parallel bits set is an illegal combination. `half_idx` = 1 means the left slot and 0 means the right slot.
- R2: While `dec_adv` is low, `half_idx` holds its value.
- R3: After reset, `half_idx`, `hit`, `miss` and `ctrl_out` are 0 and every entry is invalid, so the first lookup misses.
- R4: A store at {PC, index} followed by a lookup with the same key gives `hit`=1 and the stored word on `ctrl_out` in the cycle after the lookup.
- R5: The same PC with index 0 and with index 1 are separate entries, each returning its own word.
- R6: A lookup with no matching valid entry gives `miss`=1, `hit`=0 and `ctrl_out`=0 one cycle later.
- R7: A cycle without `fetch_mode` gives `hit`=0 and `miss`=0 one cycle later.
- R8: A store to a key that is already held replaces that entry's word. It takes no new entry, and later lookups return the newest word.
- R9: New keys fill the entries in round-robin order from entry 0 after reset or flush. With 16 entries, the 17th new key replaces the first one, and the second key is still held.
- R10: `flush` invalidates every entry and wins over a store in the same cycle. Lookups after a flush miss.
- R11: A lookup in the same cycle as a store to the same key sees the contents from before that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| dec_adv | input | 1 | Instruction moves from decode into first execute stage; loads half index |
| slot_a_par | input | 1 | Parallel bit of slot A |
| slot_b_par | input | 1 | Parallel bit of slot B |
| store_mode | input | 1 | Write the control word for the current key |
| fetch_mode | input | 1 | Look up the current key |
| pc | input | PC_W | PC of the instruction |
| ctrl_in | input | CTRL_W | Control word to store |
| hit | output | 1 | Registered lookup hit |
| miss | output | 1 | Registered lookup miss |
| ctrl_out | output | CTRL_W | Registered control word on hit, else 0 |
| half_idx | output | 1 | Current half-select index (1 left, 0 right) |

## Verification
The tracker is driven with split bundles, full bundles flagged by either slot, and idle decode cycles, so that toggling, holding and stalling can be told apart. The store is tried with distinct PCs, with one PC under both halves, with a rewrite of a held key, and with a fill beyond capacity. These patterns separate key aliasing, in-place update, and the order in which entries are replaced. A store and a lookup in the same cycle, and a flush that coincides with a store, show the ordering between the write path and the read and clear paths.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

   typedef enum logic {
      HALF_RIGHT = 1'b0,
      HALF_LEFT  = 1'b1
   } half_sel_e;

   // Next dispatch half: full bundle keeps the index, split bundle flips it.
   function automatic half_sel_e next_half(input logic change, input half_sel_e cur);
      return (change == logic'(cur)) ? HALF_LEFT : HALF_RIGHT;
   endfunction

endpackage

// File: rtl/lrb_half_tracker.sv
module lrb_half_tracker
   import lrb_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      adv,
   input  logic      par_a,
   input  logic      par_b,
   output half_sel_e idx_q
);

   logic      change;
   half_sel_e idx_d;

   assign change = par_a | par_b;

   always_comb begin
      idx_d = next_half(change, idx_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= HALF_RIGHT;
      end else if (adv) begin
         idx_q <= idx_d;
      end
   end

   AST_PAR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> !(par_a && par_b)); // R1

   AST_SPLIT_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !par_a && !par_b) |=> (idx_q != $past(idx_q))); // R1

   AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && (par_a || par_b)) |=> (idx_q == $past(idx_q))); // R1

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(idx_q)); // R2

endmodule

// File: rtl/lrb_tag_array.sv
module lrb_tag_array
   import lrb_pkg::*;
#(
   parameter int ENTRIES    = 16,
   parameter int PC_W       = 32,
   parameter int CTRL_W     = 32,
   parameter bit SEL_ONEHOT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [PC_W-1:0]   key_pc,
   input  half_sel_e         key_half,
   input  logic [CTRL_W-1:0] wr_data,
   output logic              key_hit,
   output logic [CTRL_W-1:0] rd_data
);

   localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(ENTRIES - 1);

   logic [ENTRIES-1:0] valid_q;
   logic [ENTRIES-1:0] match;
   logic [PC_W-1:0]    pc_q   [ENTRIES];
   half_sel_e          half_q [ENTRIES];
   logic [CTRL_W-1:0]  data_q [ENTRIES];
   logic [PTR_W-1:0]   alloc_q;
   logic               alloc_new;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = valid_q[g] && (pc_q[g] == key_pc) && (half_q[g] == key_half);
   end

   assign key_hit   = |match;
   assign alloc_new = wr_en && !flush && !key_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         alloc_q <= '0;
      end else if (flush) begin
         valid_q <= '0;
         alloc_q <= '0;
      end else if (alloc_new) begin
         valid_q[alloc_q] <= 1'b1;
         alloc_q          <= (alloc_q == LAST_SLOT) ? '0 : alloc_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !flush) begin
         if (key_hit) begin
            for (int i = 0; i < ENTRIES; i++) begin
               if (match[i]) data_q[i] <= wr_data;
            end
         end else begin
            pc_q[alloc_q]   <= key_pc;
            half_q[alloc_q] <= key_half;
            data_q[alloc_q] <= wr_data;
         end
      end
   end

   if (SEL_ONEHOT) begin : g_sel_andor
      always_comb begin
         rd_data = '0;
         for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) rd_data = rd_data | data_q[i];
         end
      end
   end else begin : g_sel_enc
      logic [PTR_W-1:0] sel;
      always_comb begin
         sel = '0;
         for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) sel = PTR_W'(i);
         end
         rd_data = key_hit ? data_q[sel] : '0;
      end
   end

   AST_KEY_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match)); // R8

   AST_ALLOC_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_new |=> (alloc_q != $past(alloc_q))); // R9

   AST_REWRITE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush && key_hit) |=> $stable(alloc_q)); // R8

endmodule

// File: rtl/lrb_out_stage.sv
module lrb_out_stage #(
   parameter int CTRL_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_en,
   input  logic              lk_match,
   input  logic [CTRL_W-1:0] lk_data,
   output logic              hit_q,
   output logic              miss_q,
   output logic [CTRL_W-1:0] data_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q  <= 1'b0;
         miss_q <= 1'b0;
         data_q <= '0;
      end else begin
         hit_q  <= lk_en && lk_match;
         miss_q <= lk_en && !lk_match;
         data_q <= (lk_en && lk_match) ? lk_data : '0;
      end
   end

   AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_q && miss_q)); // R6

   AST_MISS_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      miss_q |-> (data_q == '0)); // R6

   AST_LOOKUP_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_en |=> (hit_q || miss_q)); // R4

   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_en |=> (!hit_q && !miss_q)); // R7

endmodule

// File: rtl/loop_replay_buf.sv
module loop_replay_buf
   import lrb_pkg::*;
#(
   parameter int ENTRIES    = 16,
   parameter int PC_W       = 32,
   parameter int CTRL_W     = 32,
   parameter bit SEL_ONEHOT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              dec_adv,
   input  logic              slot_a_par,
   input  logic              slot_b_par,
   input  logic              store_mode,
   input  logic              fetch_mode,
   input  logic [PC_W-1:0]   pc,
   input  logic [CTRL_W-1:0] ctrl_in,
   output logic              hit,
   output logic              miss,
   output logic [CTRL_W-1:0] ctrl_out,
   output logic              half_idx
);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("loop_replay_buf: ENTRIES must be at least 2");
   end
   if (PC_W < 1) begin : g_bad_pc
      $error("loop_replay_buf: PC_W must be positive");
   end
   if (CTRL_W < 1) begin : g_bad_ctrl
      $error("loop_replay_buf: CTRL_W must be positive");
   end

   half_sel_e         cur_half;
   logic              key_hit;
   logic [CTRL_W-1:0] key_data;

   lrb_half_tracker u_tracker (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (dec_adv),
      .par_a (slot_a_par),
      .par_b (slot_b_par),
      .idx_q (cur_half)
   );

   lrb_tag_array #(
      .ENTRIES    (ENTRIES),
      .PC_W       (PC_W),
      .CTRL_W     (CTRL_W),
      .SEL_ONEHOT (SEL_ONEHOT)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .wr_en    (store_mode),
      .key_pc   (pc),
      .key_half (cur_half),
      .wr_data  (ctrl_in),
      .key_hit  (key_hit),
      .rd_data  (key_data)
   );

   lrb_out_stage #(
      .CTRL_W (CTRL_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_en    (fetch_mode),
      .lk_match (key_hit),
      .lk_data  (key_data),
      .hit_q    (hit),
      .miss_q   (miss),
      .data_q   (ctrl_out)
   );

   assign half_idx = logic'(cur_half);

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (flush ##1 fetch_mode) |=> miss); // R10

   AST_STORE_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (store_mode && !flush ##1 fetch_mode && $stable(pc) && $stable(half_idx)) |=> hit); // R4

endmodule

// File: tb/loop_replay_buf_test.sv
module loop_replay_buf_test;

   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0, dec_adv = 1'b0, slot_a_par = 1'b0, slot_b_par = 1'b0;
   logic        store_mode = 1'b0, fetch_mode = 1'b0;
   logic [31:0] pc = '0, ctrl_in = '0;
   logic        hit, miss, half_idx;
   logic [31:0] ctrl_out;

   always #5 clk = ~clk;

   loop_replay_buf uut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .dec_adv(dec_adv),
      .slot_a_par(slot_a_par), .slot_b_par(slot_b_par),
      .store_mode(store_mode), .fetch_mode(fetch_mode),
      .pc(pc), .ctrl_in(ctrl_in),
      .hit(hit), .miss(miss), .ctrl_out(ctrl_out), .half_idx(half_idx)
   );

   typedef struct {
      logic        hit;
      logic        miss;
      logic [31:0] data;
      logic        idx;
      string       tag;
   } exp_t;

   exp_t  sb[$];
   int    checks = 0;
   int    failures = 0;
   bit    finished = 1'b0;

   // reference model state
   logic        m_v [N];
   logic [31:0] m_pc[N];
   logic        m_h [N];
   logic [31:0] m_d [N];
   int          m_ptr = 0;
   logic        m_idx = 1'b0;

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic adv_i, input logic pa, input logic pb,
                       input logic st, input logic fe, input logic fl,
                       input logic [31:0] pc_i, input logic [31:0] d_i, input string tag);
      exp_t e;
      int   f;
      @(negedge clk);
      dec_adv = adv_i; slot_a_par = pa; slot_b_par = pb;
      store_mode = st; fetch_mode = fe; flush = fl; pc = pc_i; ctrl_in = d_i;
      f = -1;
      for (int i = 0; i < N; i++)
         if (m_v[i] && m_pc[i] == pc_i && m_h[i] == m_idx) f = i;
      e.hit  = fe && (f >= 0);
      e.miss = fe && (f < 0);
      e.data = '0;
      if (e.hit) e.data = m_d[f];
      if (fl) begin
         for (int i = 0; i < N; i++) m_v[i] = 1'b0;
         m_ptr = 0;
      end else if (st) begin
         if (f >= 0) m_d[f] = d_i;
         else begin
            m_v[m_ptr] = 1'b1; m_pc[m_ptr] = pc_i; m_h[m_ptr] = m_idx; m_d[m_ptr] = d_i;
            m_ptr = (m_ptr + 1) % N;
         end
      end
      if (adv_i) m_idx = ((pa | pb) == m_idx);
      e.idx = m_idx;
      e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: compares one expected item after every driven edge
   initial begin
      forever begin
         exp_t e;
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            e = sb.pop_front();
            check(e.tag, "hit", {31'b0, hit}, {31'b0, e.hit});
            check(e.tag, "miss", {31'b0, miss}, {31'b0, e.miss});
            check(e.tag, "ctrl_out", ctrl_out, e.data);
            check(e.tag, "half_idx", {31'b0, half_idx}, {31'b0, e.idx});
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_v[i] = 1'b0; m_pc[i] = '0; m_h[i] = 1'b0; m_d[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R3: reset values at the ports
      check("R3", "hit", {31'b0, hit}, 32'd0);
      check("R3", "miss", {31'b0, miss}, 32'd0);
      check("R3", "ctrl_out", ctrl_out, 32'd0);
      check("R3", "half_idx", {31'b0, half_idx}, 32'd0);
      step(0,0,0, 0,1,0, 32'h0, 32'h0, "R3");            // empty buffer misses
      // R1 / R2: half index tracker
      step(1,0,0, 0,0,0, 32'h0, 32'h0, "R1");            // split: 0 -> 1
      step(1,1,0, 0,0,0, 32'h0, 32'h0, "R1");            // full via slot A: keep 1
      step(1,0,1, 0,0,0, 32'h0, 32'h0, "R1");            // full via slot B: keep 1
      step(0,0,0, 0,0,0, 32'h0, 32'h0, "R2");            // stall: hold
      step(1,0,0, 0,0,0, 32'h0, 32'h0, "R1");            // split: 1 -> 0
      // R4: store then hit
      step(0,0,0, 1,0,0, 32'h100, 32'hAAAA0001, "R4");
      step(0,0,0, 0,1,0, 32'h100, 32'h0, "R4");
      // R5: same PC, other half
      step(1,0,0, 0,0,0, 32'h0, 32'h0, "R1");
      step(0,0,0, 0,1,0, 32'h100, 32'h0, "R5");          // idx 1 not yet stored: miss
      step(0,0,0, 1,0,0, 32'h100, 32'hBBBB0002, "R5");
      step(0,0,0, 0,1,0, 32'h100, 32'h0, "R5");
      step(1,0,0, 0,0,0, 32'h0, 32'h0, "R1");
      step(0,0,0, 0,1,0, 32'h100, 32'h0, "R5");
      // R6: unknown key
      step(0,0,0, 0,1,0, 32'h2000, 32'h0, "R6");
      // R7: no lookup
      step(0,0,0, 0,0,0, 32'h100, 32'h0, "R7");
      // R8: rewrite held key
      step(0,0,0, 1,0,0, 32'h100, 32'hCCCC0003, "R8");
      step(0,0,0, 0,1,0, 32'h100, 32'h0, "R8");
      // R11: lookup and store together
      step(0,0,0, 1,1,0, 32'h300, 32'hDDDD0004, "R11");
      step(0,0,0, 0,1,0, 32'h300, 32'h0, "R11");
      // R10: flush beats store
      step(0,0,0, 1,0,1, 32'h400, 32'hEEEE0005, "R10");
      step(0,0,0, 0,1,0, 32'h100, 32'h0, "R10");
      step(0,0,0, 0,1,0, 32'h400, 32'h0, "R10");
      // R9: round-robin replacement
      for (int k = 0; k <= N; k++)
         step(0,0,0, 1,0,0, 32'h1000 + 32'(4*k), 32'h50 + 32'(k), "R9");
      step(0,0,0, 0,1,0, 32'h1000, 32'h0, "R9");
      step(0,0,0, 0,1,0, 32'h1004, 32'h0, "R9");
      step(0,0,0, 0,1,0, 32'h1000 + 32'(4*N), 32'h0, "R9");
      step(0,0,0, 0,0,0, 32'h0, 32'h0, "R7");
      repeat (3) @(posedge clk);
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule